// File: doc/BRIEF.md
# Configuration Address Window Decoder

This block sits beside the host fabric and turns a processor access that lands in a memory-mapped configuration window into the fields of a configuration request. It produces a bus number, a device number, a function number and a dword-aligned register offset. It also classifies the request as local to the directly attached bus (type 0), as forwarded to a bus further down the hierarchy (type 1), or as addressing a bus outside the range behind this port. It does not build a packet.

The window is `2**WIN_BITS` bytes, which can be smaller than the 256 MB a full eight-bit bus field needs. To cover the missing range, a programmable target-bus value and a bus mask choose, bit by bit, whether each bus bit comes from the target value or from the access address. Five settings are loaded through a simple write port: the window base, the target bus, the mask, the secondary bus and the subordinate bus. Enumeration software can open the full range below a bridge by setting the subordinate bus to 255. All decode results are registered and appear one cycle after the access.

Top module: `ecam_decoder`

## Requirements
- R1: An access with `req_addr[31:WIN_BITS]` equal to the programmed base bits decodes. Any other access pulses `dec_miss` with `dec_valid` low and every field output zero.
- R2: The device number is offset bits 19:15 and the function number is offset bits 14:12.
- R3: The register offset output is offset bits 11:2 followed by two zero bits, so it always addresses an aligned 4-byte word.
- R4: Bus bit i is taken from target bit i when mask bit i is 1. Otherwise it is taken from offset bit 20+i, which reads as zero when 20+i is not below WIN_BITS.
- R5: A decoded bus equal to the secondary bus gives a type 0 request (`dec_type1`=0, `dec_oor`=0).
- R6: A decoded bus above the secondary bus and not above the subordinate bus gives a type 1 request (`dec_type1`=1, `dec_oor`=0).
- R7: Any other decoded bus still raises `dec_valid`, with `dec_oor`=1 and `dec_type1`=0.
- R8: The result of an access is on the outputs in the cycle after `req_valid` is sampled. In a cycle that follows one without `req_valid`, both `dec_valid` and `dec_miss` are low.
- R9: A setting written in cycle N applies to accesses presented in cycle N+1 or later. An access presented in cycle N uses the old value.
- R10: Write selector codes are 0 base (data bits 31:WIN_BITS), 1 target bus, 2 mask, 3 secondary bus and 4 subordinate bus (data bits 7:0). Codes 5 to 7 change no setting.
- R11: Reset clears all five settings to zero and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Setting write strobe |
| reg_wr_sel | input | 3 | Setting selector |
| reg_wr_data | input | ADDR_W | Setting write data |
| req_valid | input | 1 | Access strobe |
| req_addr | input | ADDR_W | Access byte address |
| dec_valid | output | 1 | Access decoded inside the window |
| dec_miss | output | 1 | Access fell outside the window |
| dec_bus | output | 8 | Decoded bus number |
| dec_dev | output | 5 | Decoded device number |
| dec_func | output | 3 | Decoded function number |
| dec_reg | output | 12 | Aligned register byte offset |
| dec_type1 | output | 1 | Request targets a bus below the secondary bus |
| dec_oor | output | 1 | Bus is outside secondary..subordinate |

## Verification
Every decode result, miss included, is due exactly one clock after the cycle in which its access is driven. A setting write reaches the decode path one clock after its own cycle. The driver pushes one expectation for every driven cycle, including idle cycles and write-only cycles. The monitor pops one expectation a short delay after each rising edge, so each comparison lands in the cycle that follows its stimulus. Expectations are computed from a shadow copy of the settings that is updated only after the same cycle's expectation has been formed, which matches the one-cycle write visibility.

// File: rtl/ecam_dec_pkg.sv
package ecam_dec_pkg;

    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FUNC_W = 3;
    localparam int REG_W  = 12;
    localparam int BUS_LSB = 20;

    localparam logic [2:0] SEL_BASE   = 3'd0;
    localparam logic [2:0] SEL_TARGET = 3'd1;
    localparam logic [2:0] SEL_MASK   = 3'd2;
    localparam logic [2:0] SEL_SEC    = 3'd3;
    localparam logic [2:0] SEL_SUB    = 3'd4;

    typedef enum logic [1:0] {
        CLS_TYPE0 = 2'd0,
        CLS_TYPE1 = 2'd1,
        CLS_RANGE = 2'd2
    } bus_cls_e;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [REG_W-1:0]  regoff;
        logic              type1;
        logic              oor;
    } dec_out_t;

endpackage

// File: rtl/ecam_cfg_regs.sv
module ecam_cfg_regs
    import ecam_dec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_sel,
    input  logic [ADDR_W-1:0]          wr_data,
    output logic [ADDR_W-WIN_BITS-1:0] base_hi,
    output logic [BUS_W-1:0]           target,
    output logic [BUS_W-1:0]           mask,
    output logic [BUS_W-1:0]           sec_bus,
    output logic [BUS_W-1:0]           sub_bus
);

    localparam int HI_W = ADDR_W - WIN_BITS;

    typedef struct packed {
        logic [HI_W-1:0]  base_hi;
        logic [BUS_W-1:0] target;
        logic [BUS_W-1:0] mask;
        logic [BUS_W-1:0] sec;
        logic [BUS_W-1:0] sub;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[WIN_BITS-1:BUS_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_BASE:   cfg_d.base_hi = wr_data[ADDR_W-1:WIN_BITS];
                SEL_TARGET: cfg_d.target  = wr_data[BUS_W-1:0];
                SEL_MASK:   cfg_d.mask    = wr_data[BUS_W-1:0];
                SEL_SEC:    cfg_d.sec     = wr_data[BUS_W-1:0];
                SEL_SUB:    cfg_d.sub     = wr_data[BUS_W-1:0];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_hi = cfg_q.base_hi;
    assign target  = cfg_q.target;
    assign mask    = cfg_q.mask;
    assign sec_bus = cfg_q.sec;
    assign sub_bus = cfg_q.sub;

endmodule

// File: rtl/ecam_bus_compose.sv
module ecam_bus_compose
    import ecam_dec_pkg::*;
(
    input  logic [BUS_W-1:0] addr_bus,
    input  logic [BUS_W-1:0] target,
    input  logic [BUS_W-1:0] mask,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output logic [BUS_W-1:0] bus,
    output bus_cls_e         cls
);

    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        assign bus[i] = mask[i] ? target[i] : addr_bus[i];
    end

    always_comb begin
        if (bus == sec_bus)                         cls = CLS_TYPE0;
        else if ((bus > sec_bus) && (bus <= sub_bus)) cls = CLS_TYPE1;
        else                                        cls = CLS_RANGE;
    end

endmodule

// File: rtl/ecam_decoder.sv
module ecam_decoder
    import ecam_dec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_valid,
    output logic              dec_miss,
    output logic [7:0]        dec_bus,
    output logic [4:0]        dec_dev,
    output logic [2:0]        dec_func,
    output logic [11:0]       dec_reg,
    output logic              dec_type1,
    output logic              dec_oor
);

    localparam int HI_W = ADDR_W - WIN_BITS;

    logic [HI_W-1:0]  base_hi;
    logic [BUS_W-1:0] target, mask, sec_bus, sub_bus;
    logic [BUS_W-1:0] addr_bus, bus;
    bus_cls_e         cls;
    logic             hit;
    dec_out_t         dec_d, dec_q;

    ecam_cfg_regs #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .base_hi (base_hi),
        .target  (target),
        .mask    (mask),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus)
    );

    for (genvar i = 0; i < BUS_W; i++) begin : g_abus
        if (BUS_LSB + i < WIN_BITS) begin : g_in
            assign addr_bus[i] = req_addr[BUS_LSB+i];
        end else begin : g_zero
            assign addr_bus[i] = 1'b0;
        end
    end

    ecam_bus_compose u_bus (
        .addr_bus (addr_bus),
        .target   (target),
        .mask     (mask),
        .sec_bus  (sec_bus),
        .sub_bus  (sub_bus),
        .bus      (bus),
        .cls      (cls)
    );

    assign hit = (req_addr[ADDR_W-1:WIN_BITS] == base_hi);

    logic unused_addr_bits;
    assign unused_addr_bits = ^req_addr[1:0];

    always_comb begin
        dec_d = '0;
        if (req_valid) begin
            if (hit) begin
                dec_d.valid  = 1'b1;
                dec_d.bus    = bus;
                dec_d.dev    = req_addr[19:15];
                dec_d.func   = req_addr[14:12];
                dec_d.regoff = {req_addr[11:2], 2'b00};
                dec_d.type1  = (cls == CLS_TYPE1);
                dec_d.oor    = (cls == CLS_RANGE);
            end else begin
                dec_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid = dec_q.valid;
    assign dec_miss  = dec_q.miss;
    assign dec_bus   = dec_q.bus;
    assign dec_dev   = dec_q.dev;
    assign dec_func  = dec_q.func;
    assign dec_reg   = dec_q.regoff;
    assign dec_type1 = dec_q.type1;
    assign dec_oor   = dec_q.oor;

endmodule

// File: rtl/ecam_decoder_chk.sv
module ecam_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              dec_valid,
    input logic              dec_miss,
    input logic [4:0]        dec_dev,
    input logic [2:0]        dec_func,
    input logic [11:0]       dec_reg,
    input logic              dec_type1,
    input logic              dec_oor
);

    AST_ACCEPT_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (dec_valid ^ dec_miss)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_miss)); // R8

    AST_MISS_NO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_miss |-> (dec_dev == '0 && dec_func == '0 && dec_reg == '0 && !dec_type1 && !dec_oor)); // R1

    AST_DEV_FUNC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 dec_valid) |-> (dec_dev == $past(req_addr[19:15]) && dec_func == $past(req_addr[14:12]))); // R2

    AST_REG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 dec_valid) |-> (dec_reg == {$past(req_addr[11:2]), 2'b00})); // R3

    AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_oor |-> (dec_valid && !dec_type1)); // R7

endmodule

bind ecam_decoder ecam_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .dec_valid (dec_valid),
    .dec_miss  (dec_miss),
    .dec_dev   (dec_dev),
    .dec_func  (dec_func),
    .dec_reg   (dec_reg),
    .dec_type1 (dec_type1),
    .dec_oor   (dec_oor)
);

// File: tb/ecam_decoder_tb.sv
module ecam_decoder_tb;
    import ecam_dec_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int WIN_BITS   = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_wr_sel = '0;
    logic [ADDR_W-1:0] reg_wr_data = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              dec_valid, dec_miss, dec_type1, dec_oor;
    logic [7:0]        dec_bus;
    logic [4:0]        dec_dev;
    logic [2:0]        dec_func;
    logic [11:0]       dec_reg;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    dec_out_t exp_q[$];
    string    tag_q[$];

    logic [ADDR_W-WIN_BITS-1:0] sh_base = '0;
    logic [7:0] sh_tgt = '0, sh_mask = '0, sh_sec = '0, sh_sub = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecam_decoder #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .req_valid(req_valid), .req_addr(req_addr),
        .dec_valid(dec_valid), .dec_miss(dec_miss), .dec_bus(dec_bus), .dec_dev(dec_dev),
        .dec_func(dec_func), .dec_reg(dec_reg), .dec_type1(dec_type1), .dec_oor(dec_oor)
    );

    function automatic dec_out_t actual();
        dec_out_t a;
        a.valid = dec_valid; a.miss = dec_miss; a.bus = dec_bus; a.dev = dec_dev;
        a.func = dec_func; a.regoff = dec_reg; a.type1 = dec_type1; a.oor = dec_oor;
        return a;
    endfunction

    function automatic dec_out_t model(bit acc, logic [ADDR_W-1:0] a);
        dec_out_t e = '0;
        if (!acc) return e;
        if (a[ADDR_W-1:WIN_BITS] != sh_base) begin
            e.miss = 1'b1;
            return e;
        end
        e.valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic ob;
            ob = (20 + i < WIN_BITS) ? a[20+i] : 1'b0;
            e.bus[i] = sh_mask[i] ? sh_tgt[i] : ob;
        end
        e.dev = a[19:15];
        e.func = a[14:12];
        e.regoff = {a[11:2], 2'b00};
        if (e.bus == sh_sec) begin
            e.type1 = 1'b0;
        end else if (e.bus > sh_sec && e.bus <= sh_sub) begin
            e.type1 = 1'b1;
        end else begin
            e.oor = 1'b1;
        end
        return e;
    endfunction

    task automatic check(string tag, dec_out_t act, dec_out_t exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one expectation per driven cycle; shadow updated after forming it
    task automatic drive(string tag, bit acc, logic [ADDR_W-1:0] addr,
                         bit wr, logic [2:0] sel, logic [ADDR_W-1:0] data);
        @(negedge clk);
        req_valid = acc; req_addr = addr;
        reg_wr_en = wr; reg_wr_sel = sel; reg_wr_data = data;
        exp_q.push_back(model(acc, addr));
        tag_q.push_back(tag);
        if (wr) begin
            case (sel)
                3'd0: sh_base = data[ADDR_W-1:WIN_BITS];
                3'd1: sh_tgt = data[7:0];
                3'd2: sh_mask = data[7:0];
                3'd3: sh_sec = data[7:0];
                3'd4: sh_sub = data[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic acc(string tag, logic [ADDR_W-1:0] addr);
        drive(tag, 1'b1, addr, 1'b0, 3'd0, '0);
    endtask

    task automatic wr(string tag, logic [2:0] sel, logic [ADDR_W-1:0] data);
        drive(tag, 1'b0, '0, 1'b1, sel, data);
    endtask

    // Monitor: pops one expectation per cycle after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            dec_out_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, actual(), e);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset outputs", actual(), dec_out_t'('0));
        @(negedge clk);
        rst_n = 1'b1;

        acc("R1 hit at base zero", 32'h0000_8000);
        acc("R1 outside window miss", 32'h1000_0000);
        drive("R9 access with same-cycle base write", 1'b1, 32'h4000_0000, 1'b1, 3'd0, 32'h4000_0000);
        acc("R9 new base used next cycle", 32'h4012_3456);
        wr("R10 write secondary", 3'd3, 32'h0000_0002);
        wr("R10 write subordinate", 3'd4, 32'h0000_00FF);
        acc("R5 bus equals secondary", 32'h4020_0000);
        acc("R6 type1 fields R2 R3", 32'h405F_F7FF);
        acc("R7 bus below secondary", 32'h4010_0000);
        drive("R8 idle cycle", 1'b0, 32'h4020_0000, 1'b0, 3'd0, '0);
        wr("R4 mask upper nibble", 3'd2, 32'h0000_00F0);
        wr("R4 target value", 3'd1, 32'h0000_003C);
        acc("R4 upper bus from target", 32'h4040_0000);
        wr("R10 shrink subordinate", 3'd4, 32'h0000_0030);
        acc("R7 bus above subordinate", 32'h4040_0000);
        wr("R10 unused selector 6", 3'd6, 32'hFFFF_FFFF);
        wr("R10 unused selector 7", 3'd7, 32'hFFFF_FFFF);
        acc("R10 settings kept after unused selectors", 32'h4040_0000);
        acc("R10 base kept after unused selectors", 32'h0000_0000);
        wr("R4 mask lower nibble", 3'd2, 32'h0000_000F);
        wr("R4 target lower", 3'd1, 32'h0000_000A);
        acc("R4 lower bus from target, upper beyond window", 32'h40F0_0000);
        wr("R10 secondary to ten", 3'd3, 32'h0000_000A);
        wr("R10 subordinate to ten", 3'd4, 32'h0000_000A);
        acc("R5 secondary equals subordinate", 32'h4000_1004);
        acc("R8 back-to-back access", 32'h4000_2FFF);
        drive("R8 trailing idle", 1'b0, '0, 1'b0, 3'd0, '0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule